// File: doc/BRIEF.md
# Windowed auto-decrement graphics fetcher

This block holds eight independent fetch pointers into a 2K×8 data array that sits beside it. A processor-side register bus at offsets 00h to 7Fh loads each pointer, sets a pair of window counts per fetcher, and reads data back. Reading a fetcher's data port returns the byte that the pointer selects and then steps the pointer down by one, so a scanline kernel can stream sprite or playfield bytes with one load per line and no pointer arithmetic of its own.

Each fetcher has a window flag. The flag turns on when the pointer's low byte reaches the fetcher's start count and turns off when it reaches the end count. Most data ports gate their byte with this flag. A sprite therefore appears only on the lines inside its window, while the pointer keeps running through the whole frame. The same byte can be read back unchanged, nibble-swapped, bit-reversed, or shifted one place either way.

The array has a synchronous read. The block drives the array address in the cycle of a bus read, and the formatted byte appears on the read data port in the following cycle.

Top module: `gfx_fetch_bank`

## Requirements
- R1: Fetcher i (i = 0..7, taken from bus_addr[2:0]) has an 11-bit pointer. A write to 50h+i loads pointer bits 7:0 from bus_wdata. A write to 58h+i loads pointer bits 10:8 from bus_wdata[2:0], and the other bits of that write are dropped.
- R2: A data-port read of fetcher i (offsets 08h–37h) fetches the array byte at address 2047 minus the pointer, then lowers the pointer by one, wrapping from 000h to 7FFh. Flag readback and unused offsets leave every pointer unchanged.
- R3: bus_addr[6:3] selects the read format. 1h returns the byte raw and never masked. 2h returns it masked. 3h swaps its nibbles, masked. 4h reverses its bit order, masked. 5h shifts it right one place with a 0 entering bit 7, masked. 6h shifts it left one place with a 0 entering bit 0, masked.
- R4: On any read at 08h–3Fh of fetcher i, the flag is set if the pointer's low byte equals the start count (written at 40h+i). Otherwise it is cleared if the low byte equals the end count (written at 48h+i). When both counts match, setting wins.
- R5: The flag update of R4 takes effect before the byte of that same read is formed, so the read that lands on the start count is already unmasked and the read that lands on the end count is already masked.
- R6: A read at 38h+i returns FFh when the flag of fetcher i is set and 00h when it is clear.
- R7: Writing a start count clears that fetcher's flag at once.
- R8: A masked port returns 00h while the flag is clear.
- R9: mem_addr carries the selected fetcher's array address during the read cycle. bus_rdata carries the result, with bus_rvalid high, in the cycle after bus_rd.
- R10: Reset clears all pointers, counts and flags, and drops bus_rvalid. Reads at unused offsets (00h–07h, 60h–7Fh) return 00h, and writes there change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 7 | Register offset 00h–7Fh |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Formatted read data, valid while bus_rvalid is high |
| bus_rvalid | output | 1 | High in the cycle after a read |
| mem_addr | output | 11 | Address to the synchronous data array |
| mem_rdata | input | 8 | Array byte, one cycle after mem_addr |

## Verification
The assertions take for granted that bus_rd and bus_wr are never high in the same cycle. They also assume that mem_rdata, one cycle after any address, is the array byte at that address. The bench gives every access its own single-cycle strobe and keeps a registered array model that follows mem_addr at every edge. Under those conditions the pointer, flag and format checks depend only on the register bus sequence.

// File: rtl/gff_pkg.sv
package gff_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        RK_NONE, RK_RAW, RK_MASK, RK_SWAP, RK_REV, RK_SHR, RK_SHL, RK_FLAG
    } rd_kind_e;

    typedef enum logic [2:0] {
        WK_NONE, WK_START, WK_END, WK_PLO, WK_PHI
    } wr_kind_e;

    typedef struct packed {
        rd_kind_e kind;
        logic     flag;
    } rd_stage_t;

    function automatic rd_kind_e decode_rd(input logic [3:0] grp);
        case (grp)
            4'h1:    return RK_RAW;
            4'h2:    return RK_MASK;
            4'h3:    return RK_SWAP;
            4'h4:    return RK_REV;
            4'h5:    return RK_SHR;
            4'h6:    return RK_SHL;
            4'h7:    return RK_FLAG;
            default: return RK_NONE;
        endcase
    endfunction

    function automatic wr_kind_e decode_wr(input logic [3:0] grp);
        case (grp)
            4'h8:    return WK_START;
            4'h9:    return WK_END;
            4'hA:    return WK_PLO;
            4'hB:    return WK_PHI;
            default: return WK_NONE;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] bit_rev(input logic [BYTE_W-1:0] d);
        logic [BYTE_W-1:0] r;
        for (int k = 0; k < BYTE_W; k++) r[k] = d[BYTE_W-1-k];
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] shape(input rd_kind_e k,
                                                input logic [BYTE_W-1:0] d,
                                                input logic f);
        logic [BYTE_W-1:0] gate;
        gate = {BYTE_W{f}};
        case (k)
            RK_RAW:  return d;
            RK_MASK: return d & gate;
            RK_SWAP: return {d[3:0], d[7:4]} & gate;
            RK_REV:  return bit_rev(d) & gate;
            RK_SHR:  return {1'b0, d[7:1]} & gate;
            RK_SHL:  return {d[6:0], 1'b0} & gate;
            RK_FLAG: return gate;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gff_slot.sv
module gff_slot
    import gff_pkg::*;
#(
    parameter int PTR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_hit,
    input  logic              step,
    input  wr_kind_e          wr_kind,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr,
    output logic              flag_eval
);
    localparam int HI_W = PTR_W - BYTE_W;

    logic [PTR_W-1:0]  ptr_q;
    logic [BYTE_W-1:0] start_q, end_q;
    logic              flag_q;
    logic [BYTE_W-1:0] low;

    assign low = ptr_q[BYTE_W-1:0];
    assign ptr = ptr_q;

    always_comb begin
        if (low == start_q)    flag_eval = 1'b1;
        else if (low == end_q) flag_eval = 1'b0;
        else                   flag_eval = flag_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q   <= '0;
            start_q <= '0;
            end_q   <= '0;
            flag_q  <= 1'b0;
        end else begin
            if (rd_hit) flag_q <= flag_eval;
            if (step)   ptr_q  <= ptr_q - 1'b1;
            case (wr_kind)
                WK_START: begin start_q <= wdata; flag_q <= 1'b0; end
                WK_END:   end_q <= wdata;
                WK_PLO:   ptr_q[BYTE_W-1:0] <= wdata;
                WK_PHI:   ptr_q[PTR_W-1:BYTE_W] <= wdata[HI_W-1:0];
                default:  ;
            endcase
        end
    end

    AST_STEP_DEC: assert property (@(posedge clk) disable iff (rst)
        step |=> ptr_q == $past(ptr_q) - 1'b1);                            // R2
    AST_START_CLR: assert property (@(posedge clk) disable iff (rst)
        wr_kind == WK_START |=> !flag_q);                                 // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!rd_hit && wr_kind == WK_NONE) |=> ($stable(ptr_q) && $stable(flag_q))); // R10
    AST_EVAL_SET: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && wr_kind == WK_NONE && low == start_q) |=> flag_q);     // R4

endmodule

// File: rtl/gff_shape.sv
module gff_shape
    import gff_pkg::*;
(
    input  rd_stage_t         stage,
    input  logic [BYTE_W-1:0] raw,
    output logic [BYTE_W-1:0] dout
);
    assign dout = shape(stage.kind, raw, stage.flag);
endmodule

// File: rtl/gfx_fetch_bank.sv
module gfx_fetch_bank
    import gff_pkg::*;
#(
    parameter int N_FETCH = 8,
    parameter int PTR_W   = 11,
    parameter int ADDR_W  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata
);
    localparam int IDX_W = $clog2(N_FETCH);
    localparam int GRP_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0] idx;
    logic [GRP_W-1:0] grp;
    rd_kind_e         rd_kind;
    wr_kind_e         wr_kind;
    logic [N_FETCH-1:0] hit;
    logic [PTR_W-1:0] ptr_a [N_FETCH];
    logic             feval [N_FETCH];
    rd_stage_t        st_q;

    assign idx     = bus_addr[IDX_W-1:0];
    assign grp     = bus_addr[ADDR_W-1:IDX_W];
    assign rd_kind = bus_rd ? decode_rd(grp) : RK_NONE;
    assign wr_kind = bus_wr ? decode_wr(grp) : WK_NONE;

    for (genvar g = 0; g < N_FETCH; g++) begin : g_slot
        logic     sel;
        wr_kind_e wk;
        assign sel    = (idx == IDX_W'(g));
        assign hit[g] = sel && (rd_kind != RK_NONE);
        assign wk     = sel ? wr_kind : WK_NONE;
        gff_slot #(.PTR_W(PTR_W)) u_slot (
            .clk       (clk),
            .rst       (rst),
            .rd_hit    (hit[g]),
            .step      (hit[g] && rd_kind != RK_FLAG),
            .wr_kind   (wk),
            .wdata     (bus_wdata),
            .ptr       (ptr_a[g]),
            .flag_eval (feval[g])
        );
    end

    assign mem_addr = ~ptr_a[idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rvalid <= 1'b0;
            st_q       <= '{kind: RK_NONE, flag: 1'b0};
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_rd) begin
                st_q.kind <= rd_kind;
                st_q.flag <= feval[idx];
            end
        end
    end

    gff_shape u_shape (
        .stage (st_q),
        .raw   (mem_rdata),
        .dout  (bus_rdata)
    );

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));                                                   // R3
    AST_RVALID_NEXT: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);                                           // R9
    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && !st_q.flag && st_q.kind inside {RK_MASK, RK_SWAP, RK_REV, RK_SHR, RK_SHL})
        |-> bus_rdata == '0);                                             // R8
    AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rvalid && st_q.kind == RK_NONE) |-> bus_rdata == '0);        // R10
    AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && bus_wr));                                             // R10

endmodule

// File: tb/gfx_fetch_bank_tb.sv
module gfx_fetch_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_rvalid;
    logic [10:0] mem_addr;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem [2048];
    logic [10:0] m_ptr [8];
    logic [7:0]  m_st [8], m_en [8];
    logic        m_fl [8];
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    gfx_fetch_bank u_dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .mem_addr(mem_addr), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) mem_rdata <= mem[mem_addr];

    task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [6:0] a, input logic [7:0] v);
        int i;
        i = int'(a[2:0]);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
        case (a[6:3])
            4'h8: begin m_st[i] = v; m_fl[i] = 1'b0; end
            4'h9: m_en[i] = v;
            4'hA: m_ptr[i][7:0] = v;
            4'hB: m_ptr[i][10:8] = v[2:0];
            default: ;
        endcase
    endtask

    function automatic logic [7:0] expect_rd(input logic [6:0] a);
        int i;
        logic [7:0] d, r, g;
        i = int'(a[2:0]);
        if (a[6:3] < 4'h1 || a[6:3] > 4'h7) return 8'h00;
        if (m_ptr[i][7:0] == m_st[i])      m_fl[i] = 1'b1;
        else if (m_ptr[i][7:0] == m_en[i]) m_fl[i] = 1'b0;
        d = mem[2047 - int'(m_ptr[i])];
        g = m_fl[i] ? 8'hFF : 8'h00;
        for (int k = 0; k < 8; k++) r[k] = d[7-k];
        if (a[6:3] != 4'h7) m_ptr[i] = m_ptr[i] - 11'd1;
        case (a[6:3])
            4'h1: return d;
            4'h2: return d & g;
            4'h3: return {d[3:0], d[7:4]} & g;
            4'h4: return r & g;
            4'h5: return (d >> 1) & g;
            4'h6: return (d << 1) & g;
            default: return g;
        endcase
    endfunction

    task automatic rd_check(input logic [6:0] a, input string req);
        logic [7:0] exp;
        exp = expect_rd(a);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check({req, " rvalid R9"}, 11'(bus_rvalid), 11'd1);
        check(req, 11'(bus_rdata), 11'(exp));
    endtask

    task automatic set_ptr(input int i, input logic [10:0] p);
        do_write(7'h50 + 7'(i), p[7:0]);
        do_write(7'h58 + 7'(i), {5'b10101, p[10:8]});
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R10 reset rvalid", 11'(bus_rvalid), 11'd0);
        bus_addr = 7'h0B;
        #1;
        check("R10 reset pointer / R9 mem_addr", mem_addr, 11'h7FF);
        rd_check(7'h3B, "R10 flag after reset reads, counts zero");
    endtask

    task automatic t_raw_stream;
        set_ptr(2, 11'h123);
        check("R1 mem_addr after pointer load", mem_addr, 11'h7FF - 11'h123);
        for (int k = 0; k < 3; k++) rd_check(7'h0A, "R2 raw stream");
        set_ptr(6, 11'h7FD);
        rd_check(7'h0E, "R1 high bits kept to three");
    endtask

    task automatic t_wrap;
        set_ptr(7, 11'h000);
        rd_check(7'h0F, "R2 read at pointer 000");
        rd_check(7'h0F, "R2 wrap to 7FF");
    endtask

    task automatic t_window;
        set_ptr(1, 11'h312);
        do_write(7'h41, 8'h10);
        do_write(7'h49, 8'h0C);
        for (int k = 0; k < 7; k++) rd_check(7'h11, "R4 R5 R8 window masked port");
        rd_check(7'h09, "R3 raw not masked with flag clear");
        set_ptr(3, 11'h020);
        do_write(7'h43, 8'h20);
        do_write(7'h4B, 8'h20);
        rd_check(7'h13, "R4 start wins over end");
    endtask

    task automatic t_formats;
        set_ptr(5, 11'h2A5);
        do_write(7'h45, 8'hA5);
        do_write(7'h4D, 8'h00);
        rd_check(7'h1D, "R3 nibble swap");
        rd_check(7'h25, "R3 bit reverse");
        rd_check(7'h2D, "R3 shift right");
        rd_check(7'h35, "R3 shift left");
        rd_check(7'h15, "R3 masked plain");
        do_write(7'h45, 8'h33);
        rd_check(7'h2D, "R8 shift right masked");
    endtask

    task automatic t_flag_port;
        set_ptr(4, 11'h140);
        do_write(7'h44, 8'h40);
        do_write(7'h4C, 8'h00);
        rd_check(7'h3C, "R6 flag reads FF");
        rd_check(7'h3C, "R6 flag read keeps pointer");
        do_write(7'h44, 8'h99);
        rd_check(7'h3C, "R7 start write clears flag");
        rd_check(7'h0C, "R2 pointer unmoved by flag reads");
    endtask

    task automatic t_unused;
        do_write(7'h62, 8'hFF);
        do_write(7'h7A, 8'h55);
        rd_check(7'h02, "R10 unused low offset");
        rd_check(7'h66, "R10 unused high offset");
        rd_check(7'h0A, "R10 unused writes leave pointer");
    endtask

    initial begin
        for (int i = 0; i < 2048; i++) mem[i] = 8'((i * 29) ^ (i >> 4) ^ 8'h5A);
        for (int i = 0; i < 8; i++) begin
            m_ptr[i] = '0; m_st[i] = '0; m_en[i] = '0; m_fl[i] = 1'b0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_raw_stream();
        t_wrap();
        t_window();
        t_formats();
        t_flag_port();
        t_unused();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule